// File: doc/BRIEF.md
# SD Command Response Receiver

This block takes in the response that a card sends on the SD command line. Once the host arms it with an enable strobe, it watches the sampled command line on SD-clock sample cycles and waits for a low start bit. It then shifts in a programmed number of bytes, most significant bit first, followed by a 7-bit CRC and a high end bit. Each completed byte is written into a small FIFO, and the host drains that FIFO one byte at a time.

At the end bit, the receiver pulses a done flag. The host control logic uses that pulse to drop its enable bit. A busy flag is raised only while bits are actually being taken in. It is kept distinct from the armed-but-waiting condition. A CRC-error flag reports a bad checksum or a bad end bit. It holds its value until the next reception is armed.

Top module: `sd_rsp_rx`

## Requirements
- R1: After reset, busy, fifoFull, crcErr and done are 0, fifoEmpty is 1 and rdData is 0.
- R2: Bits are taken only in cycles with sdSampleEn high. Once armed by enStrobe, the block raises busy one cycle after it samples cmdLine at 0 (the start bit). While it is not armed, a low cmdLine has no effect.
- R3: After the start bit, the block assembles rxBytes bytes, each from 8 consecutive sampled bits with the first sampled bit as bit 7. It writes each byte into the FIFO in arrival order. rxBytes is captured at the start bit.
- R4: The data bytes are followed by 7 CRC bits, MSB first, and one end bit. The CRC-7 uses polynomial x^7+x^3+1 with an all-zero initial value, and it covers the start bit and all data bits. crcErr is set at the end bit if the received CRC differs from the computed one or if the end bit is 0.
- R5: done is high for exactly the one cycle after the end bit is sampled. busy is 0 in that cycle. The block is then disarmed: a later start bit is ignored until the next enStrobe.
- R6: crcErr is cleared by an enStrobe accepted while idle. Otherwise it keeps its value until the next end bit.
- R7: The FIFO holds 16 bytes. fifoFull is 1 when it holds 16 bytes, fifoEmpty is 1 when it holds none, and the two are never 1 together.
- R8: rdData shows the oldest stored byte. A popStrobe on a non-empty FIFO removes that byte.
- R9: A byte that completes while the FIFO is full is dropped, and the stored bytes are unchanged.
- R10: While the FIFO is empty, rdData is 0 and popStrobe has no effect.
- R11: With rxBytes = 0, the CRC follows the start bit directly, and no byte is stored.
- R12: An enStrobe that arrives while a reception is in progress is ignored. The frame completes as though the strobe had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enStrobe | input | 1 | Arm a reception (one-cycle strobe) |
| rxBytes | input | 8 | Response length in bytes, CRC excluded |
| cmdLine | input | 1 | Sampled command line |
| sdSampleEn | input | 1 | SD clock sample enable |
| popStrobe | input | 1 | Remove the oldest FIFO byte |
| busy | output | 1 | Frame bits are being received |
| fifoFull | output | 1 | FIFO holds 16 bytes |
| fifoEmpty | output | 1 | FIFO holds no byte |
| crcErr | output | 1 | Last response had a CRC or end-bit error |
| done | output | 1 | One-cycle pulse after the end bit |
| rdData | output | 8 | Oldest FIFO byte, 0 when empty |

## Verification
The checker watches several properties on every cycle:
- full and empty are never raised together;
- done lasts a single cycle and never coincides with busy;
- busy rises only after a sampled low line;
- empty always forces rdData to zero;
- crcErr moves only at done or after an arming strobe.

The data path needs the bench's scenarios to show it is correct. Those scenarios cover byte order, CRC residue, the dropped bytes of an overlong response, the zero-length frame, a bad end bit, and disarming after completion. Each of these compares the drained bytes and the error flag against a model the bench computes from the frames it sends.

// File: rtl/sd_rsp_rx_pkg.sv
package sd_rsp_rx_pkg;
  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_DATA, ST_CRC, ST_STOP
  } rxState_t;

  typedef struct packed {
    logic clearErr;
    logic crcInit;
    logic crcShift;
    logic dataShift;
    logic push;
    logic finish;
  } rxStrobes_t;
endpackage

// File: rtl/sd_rsp_rx_ctrl.sv
module sd_rsp_rx_ctrl
  import sd_rsp_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enStrobe,
  input  logic [CNT_W-1:0] rxBytes,
  input  logic             cmdLine,
  input  logic             sdSampleEn,
  output rxStrobes_t       strobes,
  output logic             busy,
  output logic             done
);
  localparam int CRC_CW = $clog2(CRC_W);

  rxState_t          state;
  logic [2:0]        bitCnt;
  logic [CNT_W-1:0]  byteLeft;
  logic [CRC_CW-1:0] crcCnt;
  logic              startSeen;

  assign startSeen = (state == ST_WAIT) && sdSampleEn && !cmdLine;

  always_comb begin
    strobes.clearErr  = (state == ST_IDLE) && enStrobe;
    strobes.crcInit   = startSeen;
    strobes.dataShift = (state == ST_DATA) && sdSampleEn;
    strobes.crcShift  = sdSampleEn && (state == ST_DATA || state == ST_CRC);
    strobes.push      = strobes.dataShift && (bitCnt == 3'd7);
    strobes.finish    = (state == ST_STOP) && sdSampleEn;
  end

  assign busy = (state == ST_DATA) || (state == ST_CRC) || (state == ST_STOP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteLeft <= '0;
      crcCnt   <= '0;
      done     <= 1'b0;
    end else begin
      done <= strobes.finish;
      unique case (state)
        ST_IDLE: if (enStrobe) state <= ST_WAIT;
        ST_WAIT: if (startSeen) begin
          byteLeft <= rxBytes;
          bitCnt   <= '0;
          crcCnt   <= '0;
          state    <= (rxBytes == '0) ? ST_CRC : ST_DATA;
        end
        ST_DATA: if (sdSampleEn) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            byteLeft <= byteLeft - 1'b1;
            if (byteLeft == CNT_W'(1)) state <= ST_CRC;
          end
        end
        ST_CRC: if (sdSampleEn) begin
          crcCnt <= crcCnt + 1'b1;
          if (crcCnt == CRC_CW'(CRC_W - 1)) state <= ST_STOP;
        end
        ST_STOP: if (sdSampleEn) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_rsp_rx_dp.sv
module sd_rsp_rx_dp
  import sd_rsp_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic              cmdLine,
  input  logic              popStrobe,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              crcErr,
  output logic [DATA_W-1:0] rdData
);
  localparam int AW = $clog2(FIFO_DEPTH);

  logic [DATA_W-2:0] shReg;
  logic [CRC_W-1:0]  crcReg;
  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [AW:0]       count;
  logic              doPush, doPop, fb;

  assign fb        = cmdLine ^ crcReg[CRC_W-1];
  assign fifoFull  = (count == (AW+1)'(FIFO_DEPTH));
  assign fifoEmpty = (count == '0);
  assign doPush    = strobes.push && !fifoFull;
  assign doPop     = popStrobe && !fifoEmpty;
  assign rdData    = fifoEmpty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      crcReg <= '0;
      crcErr <= 1'b0;
    end else begin
      if (strobes.dataShift) shReg <= {shReg[DATA_W-3:0], cmdLine};
      if (strobes.crcInit) crcReg <= '0;
      else if (strobes.crcShift)
        crcReg <= {crcReg[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      if (strobes.clearErr) crcErr <= 1'b0;
      else if (strobes.finish) crcErr <= (crcReg != '0) || !cmdLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= {shReg, cmdLine};
        wrPtr      <= wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= rdPtr + 1'b1;
      count <= count + (AW+1)'(doPush) - (AW+1)'(doPop);
    end
  end
endmodule

// File: rtl/sd_rsp_rx.sv
module sd_rsp_rx
  import sd_rsp_rx_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enStrobe,
  input  logic [CNT_W-1:0]  rxBytes,
  input  logic              cmdLine,
  input  logic              sdSampleEn,
  input  logic              popStrobe,
  output logic              busy,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              crcErr,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);
  rxStrobes_t strobes;

  sd_rsp_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enStrobe(enStrobe), .rxBytes(rxBytes),
    .cmdLine(cmdLine), .sdSampleEn(sdSampleEn), .strobes(strobes),
    .busy(busy), .done(done)
  );

  sd_rsp_rx_dp #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdLine(cmdLine),
    .popStrobe(popStrobe), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .crcErr(crcErr), .rdData(rdData)
  );
endmodule

// File: rtl/sd_rsp_rx_chk.sv
module sd_rsp_rx_chk #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enStrobe,
  input logic [CNT_W-1:0]  rxBytes,
  input logic              cmdLine,
  input logic              sdSampleEn,
  input logic              popStrobe,
  input logic              busy,
  input logic              fifoFull,
  input logic              fifoEmpty,
  input logic              crcErr,
  input logic              done,
  input logic [DATA_W-1:0] rdData
);
  // R7
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(sdSampleEn) && !$past(cmdLine)));

  // R10
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> (rdData == '0));

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(crcErr) |-> (done || $past(enStrobe)));

  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enStrobe && !busy && !done) |=> !crcErr);
endmodule

bind sd_rsp_rx sd_rsp_rx_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sd_rsp_rx_tb.sv
module sd_rsp_rx_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enStrobe = 1'b0;
  logic [7:0] rxBytes = '0;
  logic       cmdLine = 1'b1;
  logic       sdSampleEn = 1'b0;
  logic       popStrobe = 1'b0;
  logic       busy, fifoFull, fifoEmpty, crcErr, done;
  logic [7:0] rdData;

  int errors = 0;
  int checks = 0;
  logic [7:0] expQ [$];

  always #10 clk = ~clk;

  sd_rsp_rx u_dut (
    .clk(clk), .rstN(rstN), .enStrobe(enStrobe), .rxBytes(rxBytes),
    .cmdLine(cmdLine), .sdSampleEn(sdSampleEn), .popStrobe(popStrobe),
    .busy(busy), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .crcErr(crcErr), .done(done), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crcStep(input logic [6:0] c, input logic b);
    logic f;
    f = b ^ c[6];
    return {c[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
  endfunction

  task automatic sendBit(input logic b);
    @(negedge clk);
    cmdLine = b;
    sdSampleEn = 1'b1;
    @(negedge clk);
    sdSampleEn = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic pulseEn();
    @(negedge clk);
    enStrobe = 1'b1;
    @(negedge clk);
    enStrobe = 1'b0;
  endtask

  // Sends one frame of n bytes and checks the flags at its end bit.
  task automatic sendFrame(input int n, input bit badCrc, input bit badEnd, input bit midEn);
    logic [6:0] c;
    logic [7:0] b;
    c = '0;
    pulseEn();
    rxBytes = 8'(n);
    repeat ($urandom_range(1, 3)) sendBit(1'b1);
    check(!busy, "R2 idle ones keep busy low", int'(busy), 0);
    @(negedge clk);
    cmdLine = 1'b0;
    check(!busy, "R2 no sample without sdSampleEn", int'(busy), 0);
    sendBit(1'b0);
    check(busy, "R2 busy after start bit", int'(busy), 1);
    c = crcStep(c, 1'b0);
    rxBytes = 8'($urandom);
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      for (int k = 7; k >= 0; k--) begin
        sendBit(b[k]);
        c = crcStep(c, b[k]);
      end
      if (expQ.size() < 16) expQ.push_back(b);
      if (midEn && i == 0) pulseEn();
    end
    if (badCrc) c = c ^ 7'(1 << $urandom_range(0, 6));
    for (int k = 6; k >= 0; k--) sendBit(c[k]);
    @(negedge clk);
    cmdLine = !badEnd;
    sdSampleEn = 1'b1;
    @(negedge clk);
    sdSampleEn = 1'b0;
    cmdLine = 1'b1;
    check(done, "R5 done after end bit", int'(done), 1);
    check(!busy, "R5 busy low with done", int'(busy), 0);
    check(crcErr == (badCrc || badEnd), "R4 crc/end error flag", int'(crcErr), int'(badCrc || badEnd));
    @(negedge clk);
    check(!done, "R5 done is one cycle", int'(done), 0);
    check(fifoFull == (expQ.size() == 16), "R7 full flag", int'(fifoFull), int'(expQ.size() == 16));
    check(fifoEmpty == (expQ.size() == 0), "R7 empty flag", int'(fifoEmpty), int'(expQ.size() == 0));
  endtask

  task automatic drain();
    while (expQ.size() > 0) begin
      logic [7:0] e;
      e = expQ.pop_front();
      check(rdData == e, "R8 R3 oldest byte", int'(rdData), int'(e));
      @(negedge clk);
      popStrobe = 1'b1;
      @(negedge clk);
      popStrobe = 1'b0;
    end
    check(fifoEmpty && rdData == 8'h00, "R10 empty reads zero", int'(rdData), 0);
    @(negedge clk);
    popStrobe = 1'b1;
    @(negedge clk);
    popStrobe = 1'b0;
    check(fifoEmpty && !fifoFull && rdData == 8'h00, "R10 pop on empty no effect", int'(fifoEmpty), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !fifoFull && fifoEmpty && !crcErr && !done && rdData == 0,
          "R1 reset state", int'({busy, fifoFull, fifoEmpty, crcErr, done}), 4);

    // R2: start bit while not armed is ignored
    sendBit(1'b0);
    check(!busy, "R2 unarmed start ignored", int'(busy), 0);
    sendBit(1'b1);

    // R3 R8 correct frame, R12 enable mid-frame ignored
    sendFrame(6, 1'b0, 1'b0, 1'b1);
    // R5 disarmed after done
    sendBit(1'b0);
    check(!busy, "R5 disarmed after done", int'(busy), 0);
    sendBit(1'b1);
    drain();

    // R4 bad CRC, then R6 hold and clear
    sendFrame(3, 1'b1, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check(crcErr, "R6 crcErr holds", int'(crcErr), 1);
    pulseEn();
    check(!crcErr, "R6 crcErr cleared by enable", int'(crcErr), 0);
    drain();

    // R4 bad end bit
    sendFrame(2, 1'b0, 1'b1, 1'b0);
    drain();

    // R11 zero-length response
    sendFrame(0, 1'b0, 1'b0, 1'b0);
    check(fifoEmpty, "R11 nothing stored", int'(fifoEmpty), 1);

    // R9 overlong response: bytes beyond 16 dropped
    sendFrame(19, 1'b0, 1'b0, 1'b0);
    check(fifoFull, "R9 FIFO full after overlong frame", int'(fifoFull), 1);
    drain();

    // random frames
    for (int f = 0; f < 12; f++) begin
      int n;
      n = $urandom_range(1, 16);
      sendFrame(n, ($urandom_range(0, 3) == 0), 1'b0, 1'b0);
      drain();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule